// File: doc/BRIEF.md
# Dual-Channel Converter Output Stage

This block is the digital back end of a two-channel sampling converter. Each channel receives a 10-bit raw sample word on every rising edge of its own encode clock. It carries that word through a fixed five-cycle pipeline, optionally converts it from offset binary to twos complement, and presents it on a parallel data bus that can be released to high impedance. Each channel also has a data-valid flag.

A two-bit mode input selects one of four operating modes: both channels off, channel B off, both channels running, or both running with channel B's output moved by half an encode period. With one clock shared by both channels and no alignment, the two buses change on the same rising edge. When the two encode clocks are in antiphase, alignment makes channel B's data change on channel A's rising edge. After a channel leaves power-down, it counts a wake-up period and then a pipeline refill before it raises its valid flag again.

Top module: `dual_conv_out`

## Requirements
- R1: A sample captured at a rising encode edge of its channel appears on that channel's data output right after the fifth later rising edge of the same clock.
- R2: With mode_sel = 2'b00, both data buses are high impedance and both valid flags are low.
- R3: With mode_sel = 2'b01, channel B's bus is high impedance and valid_b is low, while channel A keeps running.
- R4: With mode_sel = 2'b10 and one clock shared by both channels, both buses update on the same rising edge with the same five-cycle latency.
- R5: With mode_sel = 2'b11, channel B's output register reloads on the falling edge of enc_b, half an encode period after the unaligned timing. Channel A is unaffected.
- R6: When fmt_twos is 1, the output word is the offset-binary input with bit 9 (the MSB) inverted, which gives twos complement. When fmt_twos is 0, the word passes through unchanged. The format is applied at the final output stage.
- R7: After reset, or after a channel leaves power-down, its valid flag stays low for 10 wake-up edges plus 5 fill edges and rises right after the 15th rising edge of its encode clock. The data bus is driven throughout this wake-up time.
- R8: An active-low rst_n clears every pipeline and output register at once. While reset is held with both channels powered, both buses read zero and both valid flags are low.
- R9: With mode_sel = 2'b11 and enc_b the inverse of enc_a, channel B's data changes only at channel A's rising edge and holds through A's low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_a | input | 1 | Encode clock, channel A |
| enc_b | input | 1 | Encode clock, channel B |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Operating mode: 00 all off, 01 B off, 10 normal, 11 B half-cycle aligned |
| fmt_twos | input | 1 | 1 selects twos-complement output, 0 selects offset binary |
| raw_a | input | 10 | Raw sample word, channel A |
| raw_b | input | 10 | Raw sample word, channel B |
| dout_a | output | 10 | Channel A data, high impedance when powered down |
| dout_b | output | 10 | Channel B data, high impedance when powered down |
| valid_a | output | 1 | Channel A data valid |
| valid_b | output | 1 | Channel B data valid |

## Verification
The hardest case to reach from the ports is the half-cycle skew. It only shows when the bus is observed inside an encode period, and it looks different depending on whether the two clocks are shared or in antiphase. The stimulus derives enc_b from enc_a through a bench-controlled inversion. It samples both buses twice per A period, once in A's high phase and once in its low phase, so that each combination of clocking and alignment yields a distinct pair of expected sample indices. The wake-up count is reached by stepping from full power-down back to a running mode and checking the valid flag on every edge.

// File: rtl/dual_conv_out.sv
`timescale 1ns/1ps
module dual_conv_out #(
  parameter int W    = 10,
  parameter int LAT  = 5,
  parameter int WAKE = 10
) (
  input  logic         enc_a,
  input  logic         enc_b,
  input  logic         rst_n,
  input  logic [1:0]   mode_sel,
  input  logic         fmt_twos,
  input  logic [W-1:0] raw_a,
  input  logic [W-1:0] raw_b,
  output wire  [W-1:0] dout_a,
  output wire  [W-1:0] dout_b,
  output logic         valid_a,
  output logic         valid_b
);
  localparam int FULL = WAKE + LAT;
  localparam int CW   = $clog2(FULL + 1);

  logic pd_a, pd_b, align;
  assign pd_a  = (mode_sel == 2'b00);
  assign pd_b  = ~mode_sel[1];
  assign align = &mode_sel;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    wire          clk = (ch == 0) ? enc_a : enc_b;
    wire  [W-1:0] raw = (ch == 0) ? raw_a : raw_b;
    wire          pd  = (ch == 0) ? pd_a  : pd_b;
    logic [W-1:0] pipe [LAT];
    logic [W-1:0] oq;
    logic [CW-1:0] cnt;
    logic         full;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < LAT; i++) pipe[i] <= '0;
        oq  <= '0;
        cnt <= '0;
      end else begin
        pipe[0] <= raw;
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
        oq <= fmt_twos ? {~pipe[LAT-1][W-1], pipe[LAT-1][W-2:0]} : pipe[LAT-1];
        if (pd)                   cnt <= '0;
        else if (cnt != CW'(FULL)) cnt <= cnt + 1'b1;
      end
    end

    assign full = (cnt == CW'(FULL));
  end

  logic [W-1:0] b_skew;
  logic         b_skew_v;
  always_ff @(negedge enc_b or negedge rst_n) begin
    if (!rst_n) begin
      b_skew   <= '0;
      b_skew_v <= 1'b0;
    end else begin
      b_skew   <= g_ch[1].oq;
      b_skew_v <= g_ch[1].full;
    end
  end

  logic [W-1:0] q_a, q_b;
  assign q_a = g_ch[0].oq;
  assign q_b = align ? b_skew : g_ch[1].oq;

  assign valid_a = ~pd_a & g_ch[0].full;
  assign valid_b = ~pd_b & (align ? b_skew_v : g_ch[1].full);

  assign dout_a = pd_a ? {W{1'bz}} : q_a;
  assign dout_b = pd_b ? {W{1'bz}} : q_b;
endmodule

// File: rtl/dual_conv_out_chk.sv
`timescale 1ns/1ps
module dual_conv_out_chk #(
  parameter int W    = 10,
  parameter int LAT  = 5,
  parameter int WAKE = 10
) (
  input logic         enc_a,
  input logic         rst_n,
  input logic [1:0]   mode_sel,
  input logic         fmt_twos,
  input logic [W-1:0] raw_a,
  input logic [W-1:0] q_a,
  input logic         valid_a,
  input logic         valid_b
);
  localparam int FULL = WAKE + LAT;
  localparam int CW   = $clog2(FULL + 1);

  logic [CW-1:0] up_a;
  always_ff @(posedge enc_a or negedge rst_n) begin
    if (!rst_n)                   up_a <= '0;
    else if (mode_sel == 2'b00)   up_a <= '0;
    else if (up_a != CW'(FULL))   up_a <= up_a + 1'b1;
  end

  a_r1_latency: assert property (@(posedge enc_a) disable iff (!rst_n)
    (valid_a && $past(valid_a)) |->
      ((q_a ^ {$past(fmt_twos), {(W-1){1'b0}}}) == $past(raw_a, LAT + 1)));

  a_r2_all_down: assert property (@(posedge enc_a) disable iff (!rst_n)
    (mode_sel == 2'b00) |-> (!valid_a && !valid_b));

  a_r3_b_down: assert property (@(posedge enc_a) disable iff (!rst_n)
    (!mode_sel[1]) |-> !valid_b);

  a_r7_wake: assert property (@(posedge enc_a) disable iff (!rst_n)
    valid_a |-> (up_a == CW'(FULL)));
endmodule

bind dual_conv_out dual_conv_out_chk #(.W(W), .LAT(LAT), .WAKE(WAKE)) chk_i (
  .enc_a(enc_a), .rst_n(rst_n), .mode_sel(mode_sel), .fmt_twos(fmt_twos),
  .raw_a(raw_a), .q_a(q_a), .valid_a(valid_a), .valid_b(valid_b));

// File: tb/dual_conv_out_tb.sv
`timescale 1ns/1ps
module dual_conv_out_tb_top;
  typedef struct packed {
    logic [1:0] mode;
    logic       fmt;
    logic       binv;
    logic [5:0] ncyc;
    logic [2:0] l3;
    logic [2:0] l8;
  } ph_t;

  localparam ph_t PH [8] = '{
    '{2'b10, 1'b0, 1'b0, 6'd30, 3'd6, 3'd6},
    '{2'b10, 1'b1, 1'b0, 6'd20, 3'd6, 3'd6},
    '{2'b11, 1'b0, 1'b0, 6'd20, 3'd7, 3'd6},
    '{2'b01, 1'b1, 1'b0, 6'd20, 3'd0, 3'd0},
    '{2'b10, 1'b0, 1'b0, 6'd25, 3'd6, 3'd6},
    '{2'b00, 1'b0, 1'b0, 6'd12, 3'd0, 3'd0},
    '{2'b11, 1'b1, 1'b1, 6'd30, 3'd6, 3'd6},
    '{2'b10, 1'b0, 1'b1, 6'd20, 3'd6, 3'd5}
  };

  logic       enc_a = 1'b0;
  logic       b_inv = 1'b0;
  wire        enc_b = enc_a ^ b_inv;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b10;
  logic       fmt_twos = 1'b0;
  logic [9:0] raw_a = '0, raw_b = '0;
  tri1  [9:0] bus_a, bus_b;
  logic       valid_a, valid_b;

  int n_chk = 0, n_err = 0, cyc = 0, up_a = 0, up_b = 0;
  bit done = 0;

  always #5 enc_a = ~enc_a;

  dual_conv_out dut_i (
    .enc_a(enc_a), .enc_b(enc_b), .rst_n(rst_n), .mode_sel(mode_sel),
    .fmt_twos(fmt_twos), .raw_a(raw_a), .raw_b(raw_b),
    .dout_a(bus_a), .dout_b(bus_b), .valid_a(valid_a), .valid_b(valid_b));

  function automatic logic [9:0] pat_a(int c); return 10'((c * 29 + 7) % 1024); endfunction
  function automatic logic [9:0] pat_b(int c); return 10'((c * 53 + 300) % 1024); endfunction
  function automatic logic [9:0] cv(logic [9:0] x, logic f); return f ? (x ^ 10'h200) : x; endfunction

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    #1;
    check("R8 dout_a in reset", bus_a, 10'h000);
    check("R8 dout_b in reset", bus_b, 10'h000);
    check("R8 valid in reset", {8'd0, valid_a, valid_b}, 10'd0);
    repeat (3) @(posedge enc_a);
    #2 rst_n = 1'b1; raw_a = pat_a(0); raw_b = pat_b(0);

    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < int'(PH[p].ncyc); k++) begin
        @(posedge enc_a);
        cyc++;
        up_a = (mode_sel == 2'b00) ? 0 : ((up_a < 15) ? up_a + 1 : 15);
        up_b = (!mode_sel[1])      ? 0 : ((up_b < 15) ? up_b + 1 : 15);
        #2;
        if (k == 0) begin
          mode_sel = PH[p].mode; fmt_twos = PH[p].fmt; b_inv = PH[p].binv;
        end
        raw_a = pat_a(cyc); raw_b = pat_b(cyc);
        #1;
        if (mode_sel == 2'b00) begin
          check("R2 dout_a released", bus_a, 10'h3FF);
          check("R2 valid_a low", {9'd0, valid_a}, 10'd0);
        end else begin
          if (k >= 8)
            check(fmt_twos ? "R6 dout_a format" : "R1 dout_a latency",
                  bus_a, cv(pat_a(cyc - 6), fmt_twos));
          check("R7 valid_a wake", {9'd0, valid_a}, {9'd0, up_a >= 15});
        end
        if (PH[p].l3 == 0) begin
          check(mode_sel == 2'b00 ? "R2 dout_b released" : "R3 dout_b released", bus_b, 10'h3FF);
          check("R3 valid_b low", {9'd0, valid_b}, 10'd0);
        end else begin
          if (k >= 8)
            check(b_inv ? (mode_sel == 2'b11 ? "R9 dout_b high phase" : "R5 dout_b antiphase")
                        : (mode_sel == 2'b11 ? "R5 dout_b skew high phase" : "R4 dout_b same edge"),
                  bus_b, cv(pat_b(cyc - int'(PH[p].l3)), fmt_twos));
          if (!b_inv && mode_sel != 2'b11)
            check("R7 valid_b wake", {9'd0, valid_b}, {9'd0, up_b >= 15});
        end
        #5;
        if (PH[p].l8 != 0 && k >= 8)
          check(b_inv ? (mode_sel == 2'b11 ? "R9 dout_b held low phase" : "R5 dout_b antiphase low")
                      : (mode_sel == 2'b11 ? "R5 dout_b skew low phase" : "R4 dout_b low phase"),
                bus_b, cv(pat_b(cyc - int'(PH[p].l8)), fmt_twos));
      end
    end

    // R8: reset in the middle of running
    @(posedge enc_a);
    #2 rst_n = 1'b0;
    #1;
    check("R8 dout_a async clear", bus_a, 10'h000);
    check("R8 dout_b async clear", bus_b, 10'h000);
    check("R8 valid async clear", {8'd0, valid_a, valid_b}, 10'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule